// File: doc/BRIEF.md
# Serial Control Register Slave for a Clock Fanout Buffer

This block is the two-wire serial slave that configures a clock fanout buffer. It holds eight 8-bit control bytes. From the last two bytes it drives one enable per true/complement output pair. An oversampling system clock sees the bus through synchronized samples of SCL and SDA. The slave answers on an open-drain SDA drive, where a high `sdaDrvLow` pulls the line low.

The slave has no register addressing. A block write starts with two bytes, a command code and a byte count. Both are acknowledged and thrown away. The bytes after them fill the registers from byte 0 upward. A block read returns a byte count first and then streams the registers in order. A power-down input gates every output enable off and leaves the stored bytes untouched.

Top module: `ctl_regs_slave`

## Requirements
- R1: After reset every stored register holds FFh, all twelve bits of `pairEn` are 1 and `sdaDrvLow` is 0.
- R2: The 7-bit slave address is 6Ah. The address byte D4h selects a write and D5h selects a read, and both are acknowledged. Any other address byte is not acknowledged, and SDA stays released until the next START or STOP.
- R3: In a write, the two bytes that follow the address are acknowledged and discarded. Each later byte is acknowledged and stored in register 0, 1, 2 and so on, in arrival order.
- R4: `pairEn[11:8]` equals register 6 bits 3:0 and `pairEn[7:0]` equals register 7 bits 7:0. A 1 enables the pair.
- R5: A STOP in the middle of a byte commits nothing, and registers not yet reached keep their old values.
- R6: Data bytes beyond register 7 are acknowledged and have no effect on any register.
- R7: A read returns 08h first and then registers 0 to 7, each MSB first. Any byte after register 7 reads as FFh.
- R8: On readback, register 6 bit 7 shows the present level of `modeSel` and bits 6:4 read as 1.
- R9: A NACK from the host after a read byte ends transmission, and SDA stays released until the next START.
- R10: A repeated START resets the byte pointer, so the next write data byte goes to register 0 again.
- R11: While `pwrDownN` is 0, every bit of `pairEn` is 0. The stored registers keep their contents and drive the enables again once `pwrDownN` returns to 1.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level |
| sdaDrvLow | output | 1 | 1 pulls SDA low |
| modeSel | input | 1 | Mode-select pin level, reported in register 6 bit 7 |
| pwrDownN | input | 1 | Active-low power-down, gates all enables off |
| pairEn | output | 12 | Enable per output pair, bit n for pair n |

## Verification
The bench targets the framing corners of the block:
- A write cut off after four bits of a byte. A slave that committed on a partial shift would corrupt register 2.
- A write of ten data bytes. A pointer that wrapped would overwrite register 0 and 1, and a slave that stopped acknowledging past the end would be exposed by the ack checks.
- A foreign address and a host NACK. Both must leave SDA released, so a slave that kept driving would corrupt the bytes the bench reads as FFh.
- A repeated START in the middle of a write. It must send the next byte back to register 0, which a pointer left running would miss.
- A read with `modeSel` at both levels. It catches a register 6 readback that returns stored bits instead of the pin and the reserved ones.

// File: rtl/ctl_regs_pkg.sv
package ctl_regs_pkg;
  typedef struct packed {
    logic       shiftIn;   // capture one received bit
    logic       shiftOut;  // advance the transmit byte
    logic       loadTx;    // load next transmit byte from idx
    logic       commit;    // store received byte at idx
    logic [3:0] idx;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WRITE, ST_READ, ST_SKIP
  } busState_t;
endpackage

// File: rtl/ctl_regs_fsm.sv
module ctl_regs_fsm
  import ctl_regs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h6A,
  parameter int         SYNC_LEN   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  output strobe_t    strb,
  output logic       sdaSync,
  output logic       ackDrv,
  output logic       txAct,
  output logic       slvActive
);
  localparam int CUR  = SYNC_LEN - 2;
  localparam int PREV = SYNC_LEN - 1;

  logic [SYNC_LEN-1:0] sclPipe, sdaPipe;
  busState_t state;
  logic [3:0] bitCnt, byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_LEN-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_LEN-2:0], sdaIn};
    end
  end

  logic sclRise, sclFall, startCond, stopCond, addrHit;
  logic [3:0] byteNext;
  assign sdaSync   = sdaPipe[CUR];
  assign sclRise   = sclPipe[CUR] & ~sclPipe[PREV];
  assign sclFall   = ~sclPipe[CUR] & sclPipe[PREV];
  assign startCond = sclPipe[CUR] & sclPipe[PREV] & sdaPipe[PREV] & ~sdaPipe[CUR];
  assign stopCond  = sclPipe[CUR] & sclPipe[PREV] & ~sdaPipe[PREV] & sdaPipe[CUR];
  assign addrHit   = (rxByte[7:1] == SLAVE_ADDR);
  assign byteNext  = (byteCnt == 4'hF) ? byteCnt : byteCnt + 4'd1;
  assign slvActive = (state != ST_IDLE) && (state != ST_SKIP);

  always_comb begin
    strb = '0;
    strb.shiftIn  = sclRise && (bitCnt < 4'd8) &&
                    (state == ST_ADDR || state == ST_WRITE);
    strb.commit   = sclFall && (bitCnt == 4'd8) && (state == ST_WRITE) &&
                    (byteCnt >= 4'd2);
    strb.shiftOut = sclFall && (state == ST_READ) && txAct &&
                    (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    strb.loadTx   = sclFall && (bitCnt == 4'd9) &&
                    ((state == ST_ADDR && rxByte[0]) || state == ST_READ);
    if (bitCnt == 4'd8) strb.idx = byteCnt - 4'd2;
    else                strb.idx = (state == ST_ADDR) ? 4'd0 : byteCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      ackDrv  <= 1'b0;
      txAct   <= 1'b0;
    end else if (stopCond) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackDrv <= 1'b0;
      txAct  <= 1'b0;
    end else if (startCond) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      byteCnt <= '0;
      ackDrv  <= 1'b0;
      txAct   <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
        if (state == ST_READ && bitCnt == 4'd8 && sdaSync) state <= ST_SKIP;
      end
      if (sclFall && bitCnt == 4'd8) begin
        case (state)
          ST_ADDR:  if (addrHit) ackDrv <= 1'b1; else state <= ST_SKIP;
          ST_WRITE: ackDrv <= 1'b1;
          ST_READ:  txAct  <= 1'b0;
          default:  ;
        endcase
      end
      if (sclFall && bitCnt == 4'd9) begin
        bitCnt <= '0;
        ackDrv <= 1'b0;
        case (state)
          ST_ADDR: begin
            state   <= rxByte[0] ? ST_READ : ST_WRITE;
            byteCnt <= rxByte[0] ? 4'd1 : 4'd0;
            txAct   <= rxByte[0];
          end
          ST_WRITE: byteCnt <= byteNext;
          ST_READ: begin
            txAct   <= 1'b1;
            byteCnt <= byteNext;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_regs_data.sv
module ctl_regs_data
  import ctl_regs_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter int         PAIRS     = 12,
  parameter int         MODE_REG  = 6,
  parameter logic [7:0] COUNT_VAL = 8'd8,
  parameter logic [7:0] REG_INIT  = 8'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             sdaBit,
  input  logic             modeSel,
  input  logic             pwrDownN,
  output logic [7:0]       rxByte,
  output logic             txMsb,
  output logic [PAIRS-1:0] pairEn
);
  localparam int IW      = $clog2(NUM_REGS);
  localparam int HI_BITS = PAIRS - 8;

  logic [7:0] regFile [NUM_REGS];
  logic [7:0] txReg, viewByte;
  logic [3:0] rdIdx;

  assign rdIdx = strb.idx - 4'd1;

  always_comb begin
    if (strb.idx == 4'd0) begin
      viewByte = COUNT_VAL;
    end else if (int'(strb.idx) <= NUM_REGS) begin
      viewByte = regFile[rdIdx[IW-1:0]];
      if (int'(rdIdx) == MODE_REG) viewByte[7:4] = {modeSel, 3'b111};
    end else begin
      viewByte = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg  <= 8'hFF;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= REG_INIT;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
      if (strb.loadTx)        txReg <= viewByte;
      else if (strb.shiftOut) txReg <= {txReg[6:0], 1'b1};
      if (strb.commit && int'(strb.idx) < NUM_REGS)
        regFile[strb.idx[IW-1:0]] <= rxByte;
    end
  end

  assign txMsb  = txReg[7];
  assign pairEn = pwrDownN ? {regFile[NUM_REGS-2][HI_BITS-1:0], regFile[NUM_REGS-1]}
                           : '0;
endmodule

// File: rtl/ctl_regs_slave.sv
module ctl_regs_slave
  import ctl_regs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h6A,
  parameter int         NUM_REGS   = 8,
  parameter int         PAIRS      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDrvLow,
  input  logic             modeSel,
  input  logic             pwrDownN,
  output logic [PAIRS-1:0] pairEn
);
  strobe_t    strb;
  logic [7:0] rxByte;
  logic       sdaSync, ackDrv, txAct, txMsb, slvActive;

  ctl_regs_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_LEN(3)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rxByte(rxByte),
    .strb(strb), .sdaSync(sdaSync), .ackDrv(ackDrv), .txAct(txAct),
    .slvActive(slvActive)
  );

  ctl_regs_data #(.NUM_REGS(NUM_REGS), .PAIRS(PAIRS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaSync), .modeSel(modeSel),
    .pwrDownN(pwrDownN), .rxByte(rxByte), .txMsb(txMsb), .pairEn(pairEn)
  );

  assign sdaDrvLow = ackDrv | (txAct & ~txMsb);
endmodule

// File: rtl/ctl_regs_slave_chk.sv
module ctl_regs_slave_chk
  import ctl_regs_pkg::*;
#(
  parameter int PAIRS = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaDrvLow,
  input logic             pwrDownN,
  input logic [PAIRS-1:0] pairEn,
  input strobe_t          strb,
  input logic             slvActive
);
  AST_PWRDN_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |-> (pairEn == '0));  // R11

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sclIn, 2)) |-> $stable(sdaDrvLow));  // R12

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !slvActive |-> !sdaDrvLow);  // R2

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.shiftOut, strb.loadTx, strb.commit}));  // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && pwrDownN) |=> (!pwrDownN || $stable(pairEn)));  // R4
endmodule

bind ctl_regs_slave ctl_regs_slave_chk #(.PAIRS(PAIRS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .pwrDownN(pwrDownN), .pairEn(pairEn), .strb(strb), .slvActive(slvActive)
);

// File: tb/ctl_regs_slave_test.sv
`timescale 1ns/1ps
module ctl_regs_slave_test;
  localparam int QTR = 8;   // quarter of an SCL period, in clk cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic hostLow = 1'b0;
  logic modeSel = 1'b0;
  logic pwrDownN = 1'b1;
  logic sdaDrvLow;
  logic [11:0] pairEn;
  wire sdaLine = !(hostLow || sdaDrvLow);

  int testsRun = 0;
  int testsFailed = 0;
  int edgeViolations = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] gotQ[$];

  always #4 clk = ~clk;

  ctl_regs_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .modeSel(modeSel), .pwrDownN(pwrDownN),
    .pairEn(pairEn)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // scoreboard monitor: compares read bytes against queued expectations
  initial forever begin
    @(negedge clk);
    while (gotQ.size() > 0 && expQ.size() > 0) begin
      automatic logic [7:0] g = gotQ.pop_front();
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      checkEq(t, int'(g), int'(e));
    end
  end

  // R12 monitor: slave drive must not move while SCL is high
  logic lastDrv = 1'b0;
  logic sclHeld = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclHeld && sclIn && sdaDrvLow !== lastDrv) edgeViolations++;
    lastDrv <= sdaDrvLow;
    sclHeld <= sclIn;
  end

  task automatic busStart();
    hostLow = 1'b0; waitClk(QTR);
    sclIn = 1'b1;   waitClk(2*QTR);
    hostLow = 1'b1; waitClk(2*QTR);
    sclIn = 1'b0;   waitClk(QTR);
  endtask

  task automatic busStop();
    hostLow = 1'b1; waitClk(QTR);
    sclIn = 1'b1;   waitClk(2*QTR);
    hostLow = 1'b0; waitClk(2*QTR);
  endtask

  task automatic sendBit(input logic b);
    hostLow = !b; waitClk(QTR);
    sclIn = 1'b1; waitClk(2*QTR);
    sclIn = 1'b0; waitClk(QTR);
  endtask

  task automatic recvBit(output logic b);
    hostLow = 1'b0; waitClk(QTR);
    sclIn = 1'b1;   waitClk(QTR);
    b = sdaLine;    waitClk(QTR);
    sclIn = 1'b0;   waitClk(QTR);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    acked = !b;
  endtask

  // driver: queue the expectation, then clock the byte in
  task automatic readExpect(input logic [7:0] exp, input string tag, input logic hostAck);
    logic [7:0] v;
    logic b;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(!hostAck);
    gotQ.push_back(v);
  endtask

  task automatic writeBlock(input logic [7:0] data[$], input string tag);
    logic a;
    busStart();
    writeByte(8'hD4, a); checkEq({tag, " addr ack R2"}, a, 1);
    writeByte(8'h3C, a); checkEq({tag, " cmd ack R3"}, a, 1);
    writeByte(8'h99, a); checkEq({tag, " cnt ack R3"}, a, 1);
    foreach (data[i]) begin
      writeByte(data[i], a);
      checkEq($sformatf("%s data%0d ack R3/R6", tag, i), a, 1);
    end
    busStop();
  endtask

  task automatic readBlock(input logic [7:0] exp[8], input string tag);
    logic a;
    busStart();
    writeByte(8'hD5, a); checkEq({tag, " read addr ack R2"}, a, 1);
    readExpect(8'h08, {tag, " count R7"}, 1'b1);
    for (int i = 0; i < 8; i++)
      readExpect(exp[i], $sformatf("%s reg%0d R7/R8", tag, i), i != 7);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic a;
    logic b;
    logic [7:0] exp[8];
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    @(negedge clk);
    // R1 reset state
    checkEq("R1 pairEn reset", pairEn, 12'hFFF);
    checkEq("R1 sda released", sdaDrvLow, 0);

    // R7/R8 default readback, plus byte past the end
    exp = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'hFF};
    busStart();
    writeByte(8'hD5, a); checkEq("R2 read addr ack", a, 1);
    readExpect(8'h08, "R7 count", 1'b1);
    for (int i = 0; i < 8; i++) readExpect(exp[i], $sformatf("R1 default reg%0d", i), 1'b1);
    readExpect(8'hFF, "R7 past end", 1'b0);
    busStop();

    // R3/R4 full write
    writeBlock('{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h05, 8'hA3}, "full");
    waitClk(4); @(negedge clk);
    checkEq("R4 pair mapping", pairEn, 12'h5A3);

    // R8 mode pin high
    modeSel = 1'b1;
    readBlock('{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'hF5, 8'hA3}, "R8 modeSel");

    // R5 partial byte then STOP
    busStart();
    writeByte(8'hD4, a); writeByte(8'h00, a); writeByte(8'h00, a);
    writeByte(8'hE1, a); writeByte(8'hE2, a);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    readBlock('{8'hE1, 8'hE2, 8'h32, 8'h43, 8'h54, 8'h65, 8'hF5, 8'hA3}, "R5 partial");

    // R6 overflow past register 7
    writeBlock('{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h0C, 8'h3C, 8'h77, 8'h88}, "R6 ovf");
    waitClk(4); @(negedge clk);
    checkEq("R6 pairEn after overflow", pairEn, 12'hC3C);
    readBlock('{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hFC, 8'h3C}, "R6 ovf");

    // R2 foreign address, write then read
    busStart();
    writeByte(8'hA4, a); checkEq("R2 foreign write no ack", a, 0);
    writeByte(8'h00, a); checkEq("R2 foreign data no ack", a, 0);
    busStop();
    waitClk(4); @(negedge clk);
    checkEq("R2 pairEn untouched", pairEn, 12'hC3C);
    busStart();
    writeByte(8'hA5, a); checkEq("R2 foreign read no ack", a, 0);
    readExpect(8'hFF, "R2 foreign read released", 1'b0);
    busStop();

    // R9 host NACK ends transmission
    busStart();
    writeByte(8'hD5, a);
    readExpect(8'h08, "R9 count", 1'b1);
    readExpect(8'hA0, "R9 reg0", 1'b0);
    readExpect(8'hFF, "R9 released after nack", 1'b0);
    busStop();

    // R10 repeated START restarts at register 0
    busStart();
    writeByte(8'hD4, a); writeByte(8'h00, a); writeByte(8'h00, a);
    writeByte(8'h5A, a); writeByte(8'h5B, a);
    busStart();
    writeByte(8'hD4, a); writeByte(8'h00, a); writeByte(8'h00, a);
    writeByte(8'h6A, a); checkEq("R10 ack after restart", a, 1);
    busStop();
    readBlock('{8'h6A, 8'h5B, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hFC, 8'h3C}, "R10 restart");

    // R11 power-down gating
    pwrDownN = 1'b0;
    waitClk(3); @(negedge clk);
    checkEq("R11 enables off", pairEn, 12'h000);
    pwrDownN = 1'b1;
    waitClk(3); @(negedge clk);
    checkEq("R11 enables restored", pairEn, 12'hC3C);

    waitClk(10);
    checkEq("R12 drive changes with SCL high", edgeViolations, 0);
    checkEq("scoreboard drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule